// File: doc/BRIEF.md
# Two-Level Banked RAM Window

This block is a byte-wide RAM that answers a fixed, page-aligned range of a 16-bit CPU address space. Behind the range sit several primary banks, each split into several sub-banks. Two separate selector registers, one for the primary bank and one for the sub-bank, pick which pair the CPU reaches. An access at address A inside the range lands at offset A minus the base in the selected pair. The legal parameter space is checked when the design is elaborated: a base that is not a multiple of 256, a size that is not a whole number of 256-byte pages, or a range that runs past the top of the address space stops elaboration with an error.

A reboot strobe, and also reset, zeroes both selectors and starts a clearing sweep over every storage byte, one byte per cycle. A small state machine runs this sweep. It has two states. CLEARING is entered from reset, and also through the REBOOT transition from either state. READY is entered through the SWEEP_DONE transition once the last byte has been cleared. While the sweep runs, `busy` is high and CPU accesses are shut out.

Top module: `bankwin_top`

## Requirements
- R1: Only addresses from BASE_ADDR to BASE_ADDR + 256*PAGES - 1 take part. A write outside that range changes no storage, and a read outside it returns 0x00.
- R2: Read data is registered. `cpu_rdata` takes the addressed byte at the clock edge where `cpu_rd` is sampled high, and it holds its value on every cycle without a read. When `cpu_wr` and `cpu_rd` are both high, the read returns the contents from before the write.
- R3: Writing the primary selector alone leaves the sub-bank selector unchanged. Later accesses reach the pair (new primary, current sub-bank).
- R4: Writing the sub-bank selector alone leaves the primary selector unchanged. Later accesses reach the pair (current primary, new sub-bank).
- R5: Each (primary, sub-bank) pair is separate storage of 256*PAGES bytes. A write to one pair is never seen through any other pair.
- R6: A selector write sampled at a clock edge applies to accesses sampled at later edges. An access sampled at the same edge as the selector write still uses the old selection.
- R7: A selector write with a value at or above its limit (NUM_PRI for the primary selector, NUM_SUB for the sub-bank selector) leaves that selector unchanged and sets `sel_err`. `sel_err` stays set until the next reboot or reset.
- R8: After a reboot is sampled, both selectors read as 0 and `sel_err` is 0. `busy` is high for exactly NUM_PRI*NUM_SUB*PAGES*256 cycles. Afterwards every byte of every pair reads 0x00.
- R9: While `busy` is high, CPU writes change nothing and CPU reads return 0x00.
- R10: During reset and right after it, `busy` is 1, `sel_err` is 0 and `cpu_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| pri_we | input | 1 | Primary selector write strobe |
| pri_val | input | SEL_W | New primary bank number |
| sub_we | input | 1 | Sub-bank selector write strobe |
| sub_val | input | SEL_W | New sub-bank number |
| reboot | input | 1 | Clear all storage and zero both selectors |
| busy | output | 1 | Clearing sweep in progress |
| sel_err | output | 1 | Sticky flag for a rejected selector value |

## Verification
The hardest situation to reach is a CPU write that arrives in the middle of a clearing sweep, at a byte the sweep has already passed. If such a write leaked through, the sweep would not overwrite it. The stimulus starts a reboot and waits a few cycles, so the sweep has passed offset 0 of pair (0,0). It then writes and reads that offset, and reads it again once `busy` falls. A second delicate case is a selector write and a read sampled at the same edge. The stimulus drives both on one cycle and expects the byte from the old pair.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
    typedef enum logic [0:0] {
        CLEARING = 1'b0,
        READY    = 1'b1
    } win_state_t;
endpackage

// File: rtl/bankwin_sel.sv
module bankwin_sel #(
    parameter int SEL_W = 3,
    parameter int LIMIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reboot,
    input  logic             we,
    input  logic [SEL_W-1:0] val,
    output logic [SEL_W-1:0] sel,
    output logic             reject
);
    logic legal;

    always_comb begin
        legal  = (int'(val) < LIMIT);
        reject = we && !reboot && !legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               sel <= '0;
        else if (reboot)          sel <= '0;
        else if (we && legal)     sel <= val;
    end

    // R8
    sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reboot |=> (sel == '0));
    // R7
    sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !reboot && int'(val) >= LIMIT) |=> $stable(sel));
endmodule

// File: rtl/bankwin_clr.sv
module bankwin_clr
    import bankwin_pkg::*;
#(
    parameter int TOTAL = 2048,
    localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reboot,
    output logic             busy,
    output logic             clr_we,
    output logic [IDX_W-1:0] clr_idx
);
    win_state_t state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic last;

    always_comb last = (int'(cnt_q) == TOTAL - 1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLEARING: if (reboot)    state_d = CLEARING;
                      else if (last) state_d = READY;
            READY:    if (reboot)    state_d = CLEARING;
            default:                 state_d = CLEARING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLEARING;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (reboot || state_q == READY) cnt_q <= '0;
            else if (!last)                 cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy    = 1'b0;
        clr_we  = 1'b0;
        clr_idx = cnt_q;
        unique case (state_q)
            CLEARING: begin busy = 1'b1; clr_we = 1'b1; end
            READY:    begin busy = 1'b0; clr_we = 1'b0; end
            default:  begin busy = 1'b1; clr_we = 1'b0; end
        endcase
    end

    // R8
    reboot_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reboot |=> busy);
    // R8
    sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last && !reboot) |=> !busy);
endmodule

// File: rtl/bankwin_store.sv
module bankwin_store #(
    parameter int TOTAL = 2048,
    localparam int IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdat,
    input  logic             re,
    input  logic             rzero,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    logic [7:0] mem [TOTAL];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (re)    rdata <= rzero ? 8'h00 : mem[ridx];
    end

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
endmodule

// File: rtl/bankwin_top.sv
module bankwin_top #(
    parameter int BASE_ADDR = 'hD000,
    parameter int PAGES     = 2,
    parameter int NUM_PRI   = 2,
    parameter int NUM_SUB   = 2,
    parameter int SEL_W     = 3,
    localparam int WIN_BYTES = PAGES * 256,
    localparam int TOTAL     = NUM_PRI * NUM_SUB * WIN_BYTES,
    localparam int IDX_W     = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      cpu_addr,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic             pri_we,
    input  logic [SEL_W-1:0] pri_val,
    input  logic             sub_we,
    input  logic [SEL_W-1:0] sub_val,
    input  logic             reboot,
    output logic             busy,
    output logic             sel_err
);
    if ((BASE_ADDR % 256) != 0 || PAGES < 1 || BASE_ADDR < 0 ||
        (BASE_ADDR + WIN_BYTES) > 65536) begin : g_bad_params
        $error("bankwin_top: window must be page aligned and fit in 64 KB");
    end

    logic [SEL_W-1:0] pri_q, sub_q;
    logic             pri_rej, sub_rej;
    logic             clr_we;
    logic [IDX_W-1:0] clr_idx;
    logic             hit;
    int               off;
    logic [IDX_W-1:0] cpu_idx;
    logic             mem_we;
    logic [IDX_W-1:0] mem_widx;
    logic [7:0]       mem_wdat;

    bankwin_sel #(.SEL_W(SEL_W), .LIMIT(NUM_PRI)) u_pri (
        .clk(clk), .rst_n(rst_n), .reboot(reboot),
        .we(pri_we), .val(pri_val), .sel(pri_q), .reject(pri_rej));

    bankwin_sel #(.SEL_W(SEL_W), .LIMIT(NUM_SUB)) u_sub (
        .clk(clk), .rst_n(rst_n), .reboot(reboot),
        .we(sub_we), .val(sub_val), .sel(sub_q), .reject(sub_rej));

    bankwin_clr #(.TOTAL(TOTAL)) u_clr (
        .clk(clk), .rst_n(rst_n), .reboot(reboot),
        .busy(busy), .clr_we(clr_we), .clr_idx(clr_idx));

    always_comb begin
        hit     = (int'(cpu_addr) >= BASE_ADDR) &&
                  (int'(cpu_addr) < BASE_ADDR + WIN_BYTES);
        off     = int'(cpu_addr) - BASE_ADDR;
        cpu_idx = IDX_W'((int'(pri_q) * NUM_SUB + int'(sub_q)) * WIN_BYTES + off);
        if (clr_we) begin
            mem_we   = 1'b1;
            mem_widx = clr_idx;
            mem_wdat = 8'h00;
        end else begin
            mem_we   = cpu_wr && hit;
            mem_widx = cpu_idx;
            mem_wdat = cpu_wdata;
        end
    end

    bankwin_store #(.TOTAL(TOTAL)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .widx(mem_widx), .wdat(mem_wdat),
        .re(cpu_rd), .rzero(busy || !hit), .ridx(cpu_idx),
        .rdata(cpu_rdata));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   sel_err <= 1'b0;
        else if (reboot)              sel_err <= 1'b0;
        else if (pri_rej || sub_rej)  sel_err <= 1'b1;
    end

    // R9
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_rd) |=> (cpu_rdata == 8'h00));
    // R1
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !hit) |=> (cpu_rdata == 8'h00));
    // R4
    pri_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_we && !pri_we && !reboot) |=> $stable(pri_q));
    // R3
    sub_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_we && !sub_we && !reboot) |=> $stable(sub_q));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_err && !reboot) |=> sel_err);
endmodule

// File: tb/sim_bankwin_top.sv
`timescale 1ns/1ps
module sim_bankwin_top;
    localparam int TOTAL = 2048;
    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  pri;
        logic [2:0]  sub;
        logic [15:0] addr;
        logic [7:0]  dat;
    } vec_t;
    localparam logic [1:0] OP_SEL = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
    localparam vec_t VT [18] = '{
        '{OP_SEL, 3'd0, 3'd0, 16'h0000, 8'h00},
        '{OP_WR,  3'd0, 3'd0, 16'hD000, 8'h11},
        '{OP_WR,  3'd0, 3'd0, 16'hD1FF, 8'hA1},
        '{OP_SEL, 3'd0, 3'd1, 16'h0000, 8'h00},
        '{OP_WR,  3'd0, 3'd0, 16'hD000, 8'h22},
        '{OP_SEL, 3'd1, 3'd1, 16'h0000, 8'h00},
        '{OP_WR,  3'd0, 3'd0, 16'hD000, 8'h33},
        '{OP_SEL, 3'd1, 3'd0, 16'h0000, 8'h00},
        '{OP_WR,  3'd0, 3'd0, 16'hD000, 8'h44},
        '{OP_RD,  3'd0, 3'd0, 16'hD000, 8'h44},
        '{OP_SEL, 3'd0, 3'd0, 16'h0000, 8'h00},
        '{OP_RD,  3'd0, 3'd0, 16'hD000, 8'h11},
        '{OP_RD,  3'd0, 3'd0, 16'hD1FF, 8'hA1},
        '{OP_SEL, 3'd0, 3'd1, 16'h0000, 8'h00},
        '{OP_RD,  3'd0, 3'd0, 16'hD000, 8'h22},
        '{OP_RD,  3'd0, 3'd0, 16'hD1FF, 8'h00},
        '{OP_SEL, 3'd1, 3'd1, 16'h0000, 8'h00},
        '{OP_RD,  3'd0, 3'd0, 16'hD000, 8'h33}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic pri_we = 1'b0, sub_we = 1'b0, reboot = 1'b0;
    logic [2:0] pri_val = '0, sub_val = '0;
    logic busy, sel_err;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    bankwin_top u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pri_we(pri_we), .pri_val(pri_val), .sub_we(sub_we), .sub_val(sub_val),
        .reboot(reboot), .busy(busy), .sel_err(sel_err));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sel_both(input logic [2:0] p, input logic [2:0] s);
        @(negedge clk); pri_we = 1; sub_we = 1; pri_val = p; sub_val = s;
        @(negedge clk); pri_we = 0; sub_we = 0;
    endtask

    task automatic sel_pri(input logic [2:0] p);
        @(negedge clk); pri_we = 1; pri_val = p;
        @(negedge clk); pri_we = 0;
    endtask

    task automatic sel_sub(input logic [2:0] s);
        @(negedge clk); sub_we = 1; sub_val = s;
        @(negedge clk); sub_we = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk); cpu_rd = 1; cpu_addr = a;
        @(negedge clk); cpu_rd = 0; d = cpu_rdata;
    endtask

    task automatic do_reboot();
        @(negedge clk); reboot = 1;
        @(negedge clk); reboot = 0;
    endtask

    task automatic wait_ready();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (2) @(negedge clk);
        check("R10 busy", int'(busy), 1);
        check("R10 sel_err", int'(sel_err), 0);
        check("R10 rdata", int'(cpu_rdata), 0);
        rst_n = 1;
        @(negedge clk);
        check("R10 busy after release", int'(busy), 1);
        wait_ready();

        // R5 table walk over all four pairs
        for (int i = 0; i < 18; i++) begin
            unique case (VT[i].op)
                OP_SEL: sel_both(VT[i].pri, VT[i].sub);
                OP_WR:  wr(VT[i].addr, VT[i].dat);
                default: begin
                    rd(VT[i].addr, d);
                    check("R5 table read", int'(d), int'(VT[i].dat));
                end
            endcase
        end

        // R3: pri only, sub stays 1 -> (0,1)
        sel_pri(3'd0); rd(16'hD000, d); check("R3", int'(d), 8'h22);
        // R4: sub only, pri stays 0 -> (0,0)
        sel_sub(3'd0); rd(16'hD000, d); check("R4", int'(d), 8'h11);

        // R2: hold without reads, even across a write
        wr(16'hD000, 8'h55); repeat (3) @(negedge clk);
        check("R2 hold", int'(cpu_rdata), 8'h11);
        // R2: simultaneous read and write gives old contents
        @(negedge clk); cpu_rd = 1; cpu_wr = 1; cpu_addr = 16'hD001; cpu_wdata = 8'h66;
        @(negedge clk); cpu_rd = 0; cpu_wr = 0;
        check("R2 read-before-write", int'(cpu_rdata), 0);
        rd(16'hD001, d); check("R2 write landed", int'(d), 8'h66);
        wr(16'hD000, 8'h11);

        // R6: selector write and read sampled on the same edge
        @(negedge clk); pri_we = 1; pri_val = 3'd1; cpu_rd = 1; cpu_addr = 16'hD000;
        @(negedge clk); pri_we = 0; cpu_rd = 0;
        check("R6 same edge old pair", int'(cpu_rdata), 8'h11);
        rd(16'hD000, d); check("R6 next access new pair", int'(d), 8'h44);

        // R7: out-of-range values rejected
        sel_pri(3'd5);
        check("R7 sel_err", int'(sel_err), 1);
        rd(16'hD000, d); check("R7 pri kept", int'(d), 8'h44);
        sel_sub(3'd2);
        rd(16'hD000, d); check("R7 sub kept", int'(d), 8'h44);
        repeat (3) @(negedge clk);
        check("R7 sticky", int'(sel_err), 1);

        // R1: outside the window
        sel_both(3'd0, 3'd0);
        wr(16'hD200, 8'hEE);
        wr(16'hCFFF, 8'hEF);
        rd(16'hD200, d); check("R1 read above", int'(d), 0);
        rd(16'hCFFF, d); check("R1 read below", int'(d), 0);
        sel_both(3'd0, 3'd1);
        rd(16'hD000, d); check("R1 no alias above", int'(d), 8'h22);
        sel_both(3'd1, 3'd1);
        rd(16'hD1FF, d); check("R1 no alias below", int'(d), 0);

        // R8: reboot sweep length, selectors zeroed, storage cleared
        @(negedge clk); reboot = 1;
        @(negedge clk); reboot = 0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R8 sweep cycles", n, TOTAL);
        check("R8 sel_err cleared", int'(sel_err), 0);
        wr(16'hD000, 8'h5A);
        sel_both(3'd1, 3'd1);
        rd(16'hD000, d); check("R8 pair cleared", int'(d), 0);
        sel_both(3'd0, 3'd1);
        rd(16'hD000, d); check("R8 pair cleared 2", int'(d), 0);
        sel_both(3'd0, 3'd0);
        rd(16'hD000, d); check("R8 selectors zeroed", int'(d), 8'h5A);
        rd(16'hD1FF, d); check("R8 far byte cleared", int'(d), 0);

        // R9: accesses during the sweep
        do_reboot();
        repeat (4) @(negedge clk);
        wr(16'hD000, 8'h77);
        rd(16'hD000, d); check("R9 read while busy", int'(d), 0);
        check("R9 still busy", int'(busy), 1);
        wait_ready();
        rd(16'hD000, d); check("R9 write dropped", int'(d), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule